// File: doc/BRIEF.md
# Prefetching Division-Free Particle Resampler

This block performs the resampling step of a particle filter. After a start strobe it takes a particle count and the sum of all particle weights. For each random threshold it receives, it walks through the raw weights in a weight memory and adds them up as it goes. It emits the first particle index at which the scaled running sum passes the scaled threshold. Heavy particles therefore come out many times and light ones seldom or never. The result is a list of surviving particle indices, one per random value, followed by a done pulse.

The threshold test needs no division. The running sum is multiplied by the range of the random value, the random value is multiplied by the weight total, and the two products are compared. Because of this, the particle count may be any value from 1 up to the maximum, and the random values may arrive in any order. No cumulative-sum memory exists.

A small prefetch buffer holds weights read ahead from the memory. It refills from address zero while the block waits for the next random value, so the following walk can start at once. The block stalls whenever that buffer runs empty.

Top module: `particle_resampler`

## Requirements
- R1: `start` is accepted only while `busy` is low. On acceptance the block latches `num_particles` and `weight_total`. A `start` pulse during a run is ignored and does not change that run's output.
- R2: For a random value u of RND_W bits, the emitted index is the smallest i such that (w[0]+...+w[i]) * 2^RND_W > u * weight_total, evaluated exactly in integers. If no index meets this, index n-1 is emitted.
- R3: Random values are taken one per `rnd_valid`/`rnd_ready` handshake, in arrival order and without sorting. Each one produces exactly one `out_valid` index, in the same order, and exactly n values are taken per run.
- R4: Exactly n indices are emitted per run. `done` is high for a single cycle, one cycle after the last `out_valid`, and never in the same cycle as `out_valid`.
- R5: Any particle count from 1 to NP_MAX works, including counts that are not powers of two, and every emitted index is below n.
- R6: `wt_rd_addr` is below the latched n whenever `wt_rd_en` is high. Read data returns one cycle after `wt_rd_en`.
- R7: A particle whose weight is zero is never emitted, given weight_total > 0 and equal to the sum of the weights.
- R8: `rnd_ready` is high only while the block is busy and waiting for a random value. While the prefetch buffer is empty the walk stalls and no index is emitted in the next cycle.
- R9: After reset, `out_valid`, `done`, `busy`, `rnd_ready` and `wt_rd_en` are all low.
- R10: While waiting for the first random value of a run, the block reads exactly min(PF_DEPTH, n) weights, from address 0 upward, and then stops reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| num_particles | input | CNT_W | Particle count n, 1..NP_MAX |
| weight_total | input | TOT_W | Sum of all n weights |
| wt_rd_en | output | 1 | Weight memory read request |
| wt_rd_addr | output | IDX_W | Weight memory read address |
| wt_rd_data | input | W_W | Weight read data, one cycle after request |
| rnd_valid | input | 1 | Random value offered |
| rnd_data | input | RND_W | Random value, uniform over 0..2^RND_W-1 |
| rnd_ready | output | 1 | Block takes a random value this cycle |
| out_valid | output | 1 | Surviving index present |
| out_index | output | IDX_W | Surviving particle index |
| done | output | 1 | One-cycle pulse after the last index |
| busy | output | 1 | Run in progress |

## Verification
The bench uses the default build: NP_MAX = 16, 8-bit weights, 8-bit random values and a five-entry prefetch buffer. With these values it can compute every expected index in plain integer arithmetic. It exercises counts 1, 2, 3, 5, 7, 8, 13 and 16, so both buffer-limited and count-limited prefetch cases and several counts that are not powers of two are covered. It uses uniform, ramped, pseudo-random and single-heavy weight patterns, and includes the extreme random values 0 and 255. Random-value gaps and an ignored mid-run start are also exercised.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT_RND,
    RS_SCAN,
    RS_FIN
  } rs_state_e;

  // Product of two unsigned operands, widened so nothing is lost.
  function automatic logic [63:0] cross_term(input logic [31:0] a, input logic [31:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

endpackage

// File: rtl/rsmp_cmp.sv
module rsmp_cmp #(
  parameter int TOT_W = 12,
  parameter int RND_W = 8
) (
  input  logic [TOT_W-1:0] cum,
  input  logic [RND_W-1:0] rnd,
  input  logic [TOT_W-1:0] total,
  output logic             hit
);
  import rsmp_pkg::*;

  localparam int RANGE = 1 << RND_W;

  logic [63:0] cum_scaled;
  logic [63:0] rnd_scaled;

  // Two multipliers replace the division by the weight total.
  always_comb begin
    cum_scaled = cross_term(32'(cum), 32'(RANGE));
    rnd_scaled = cross_term(32'(rnd), 32'(total));
    hit        = cum_scaled > rnd_scaled;
  end

endmodule

// File: rtl/rsmp_fetch.sv
module rsmp_fetch #(
  parameter int D     = 5,
  parameter int W_W   = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             enable,
  input  logic [CNT_W-1:0] n,
  input  logic             pop,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [W_W-1:0]   rd_data,
  output logic             head_valid,
  output logic [W_W-1:0]   head_data
);
  localparam int PTR_W = (D > 1) ? $clog2(D) : 1;
  localparam int OCC_W = $clog2(D + 1);

  logic [W_W-1:0]   buf_q [D];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic             pend;
  logic [CNT_W-1:0] addr_q;
  logic             push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == D - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_en      = enable && !restart && (addr_q < n) && ((int'(occ) + int'(pend)) < D);
    rd_addr    = addr_q[IDX_W-1:0];
    push       = pend && !restart;
    head_valid = (occ != '0);
    do_pop     = pop && head_valid;
    head_data  = buf_q[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      pend   <= 1'b0;
      addr_q <= '0;
    end else if (restart) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      pend   <= 1'b0;
      addr_q <= '0;
    end else begin
      pend <= rd_en;
      if (rd_en) addr_q <= addr_q + 1'b1;
      if (push) wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      occ <= occ + OCC_W'(push) - OCC_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) buf_q[wr_ptr] <= rd_data;
  end

endmodule

// File: rtl/particle_resampler.sv
module particle_resampler #(
  parameter int NP_MAX   = 16,
  parameter int W_W      = 8,
  parameter int RND_W    = 8,
  parameter int PF_DEPTH = 5,
  localparam int IDX_W   = $clog2(NP_MAX),
  localparam int CNT_W   = $clog2(NP_MAX + 1),
  localparam int TOT_W   = W_W + $clog2(NP_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num_particles,
  input  logic [TOT_W-1:0] weight_total,
  output logic             wt_rd_en,
  output logic [IDX_W-1:0] wt_rd_addr,
  input  logic [W_W-1:0]   wt_rd_data,
  input  logic             rnd_valid,
  input  logic [RND_W-1:0] rnd_data,
  output logic             rnd_ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index,
  output logic             done,
  output logic             busy
);
  import rsmp_pkg::*;

  rs_state_e        state;
  logic [CNT_W-1:0] n_q, emit_cnt;
  logic [TOT_W-1:0] tot_q, cum_q, cum_next;
  logic [RND_W-1:0] u_q;
  logic [IDX_W-1:0] scan_idx;
  logic             out_valid_q, done_q;
  logic [IDX_W-1:0] out_index_q;

  // Named internal events, also watched by the checker.
  logic start_acc, rnd_take, take_step, scan_stall, emit, last_emit;
  logic at_last, cmp_hit, fetch_restart, fetch_enable, fetch_pop;
  logic head_valid;
  logic [W_W-1:0] head_data;

  always_comb begin
    start_acc     = start && (state == RS_IDLE);
    rnd_take      = (state == RS_WAIT_RND) && rnd_valid;
    take_step     = (state == RS_SCAN) && head_valid;
    scan_stall    = (state == RS_SCAN) && !head_valid;
    cum_next      = cum_q + TOT_W'(head_data);
    at_last       = (CNT_W'(scan_idx) == n_q - 1'b1);
    emit          = take_step && (cmp_hit || at_last);
    last_emit     = emit && (emit_cnt == n_q - 1'b1);
    fetch_restart = start_acc || emit;
    fetch_enable  = (state == RS_WAIT_RND) || (state == RS_SCAN);
    fetch_pop     = take_step && !emit;
  end

  rsmp_fetch #(
    .D(PF_DEPTH), .W_W(W_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (fetch_restart),
    .enable    (fetch_enable),
    .n         (n_q),
    .pop       (fetch_pop),
    .rd_en     (wt_rd_en),
    .rd_addr   (wt_rd_addr),
    .rd_data   (wt_rd_data),
    .head_valid(head_valid),
    .head_data (head_data)
  );

  rsmp_cmp #(.TOT_W(TOT_W), .RND_W(RND_W)) u_cmp (
    .cum  (cum_next),
    .rnd  (u_q),
    .total(tot_q),
    .hit  (cmp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= RS_IDLE;
      n_q         <= '0;
      tot_q       <= '0;
      u_q         <= '0;
      cum_q       <= '0;
      scan_idx    <= '0;
      emit_cnt    <= '0;
      out_valid_q <= 1'b0;
      out_index_q <= '0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= emit;
      done_q      <= (state == RS_FIN);
      if (emit) out_index_q <= scan_idx;
      unique case (state)
        RS_IDLE: if (start_acc) begin
          n_q      <= num_particles;
          tot_q    <= weight_total;
          emit_cnt <= '0;
          state    <= RS_WAIT_RND;
        end
        RS_WAIT_RND: if (rnd_take) begin
          u_q      <= rnd_data;
          cum_q    <= '0;
          scan_idx <= '0;
          state    <= RS_SCAN;
        end
        RS_SCAN: if (emit) begin
          emit_cnt <= emit_cnt + 1'b1;
          state    <= last_emit ? RS_FIN : RS_WAIT_RND;
        end else if (take_step) begin
          cum_q    <= cum_next;
          scan_idx <= scan_idx + 1'b1;
        end
        RS_FIN: state <= RS_IDLE;
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign rnd_ready = (state == RS_WAIT_RND);
  assign out_valid = out_valid_q;
  assign out_index = out_index_q;
  assign done      = done_q;
  assign busy      = (state != RS_IDLE);

endmodule

// File: rtl/rsmp_chk.sv
module rsmp_chk #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wt_rd_en,
  input logic [IDX_W-1:0] wt_rd_addr,
  input logic [CNT_W-1:0] n_q,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_index,
  input logic             done,
  input logic             start_acc,
  input logic             scan_stall,
  input logic             rnd_ready,
  input logic             busy
);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (start_acc) seen <= '0;
    else if (out_valid) seen <= seen + 1'b1;
  end

  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wt_rd_en |-> (CNT_W'(wt_rd_addr) < n_q));

  p_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CNT_W'(out_index) < n_q));

  p_done_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen == n_q));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_stall |=> !out_valid);

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> busy);

endmodule

bind particle_resampler rsmp_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wt_rd_en  (wt_rd_en),
  .wt_rd_addr(wt_rd_addr),
  .n_q       (n_q),
  .out_valid (out_valid),
  .out_index (out_index),
  .done      (done),
  .start_acc (start_acc),
  .scan_stall(scan_stall),
  .rnd_ready (rnd_ready),
  .busy      (busy)
);

// File: tb/particle_resampler_tb.sv
module particle_resampler_tb;
  localparam int NP = 16;
  localparam int WW = 8;
  localparam int RW = 8;
  localparam int PF = 5;
  localparam int IW = $clog2(NP);
  localparam int CW = $clog2(NP + 1);
  localparam int TW = WW + $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] num_particles = '0;
  logic [TW-1:0] weight_total = '0;
  logic wt_rd_en;
  logic [IW-1:0] wt_rd_addr;
  logic [WW-1:0] wt_rd_data;
  logic rnd_valid, rnd_ready;
  logic [RW-1:0] rnd_data;
  logic out_valid, done, busy;
  logic [IW-1:0] out_index;

  always #2 clk = ~clk;

  particle_resampler #(.NP_MAX(NP), .W_W(WW), .RND_W(RW), .PF_DEPTH(PF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_particles(num_particles),
    .weight_total(weight_total), .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr),
    .wt_rd_data(wt_rd_data), .rnd_valid(rnd_valid), .rnd_data(rnd_data),
    .rnd_ready(rnd_ready), .out_valid(out_valid), .out_index(out_index),
    .done(done), .busy(busy)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [WW-1:0] wmem [NP];
  int rlist [NP];
  int expv [NP];
  int cur_n = 1;
  int ocnt = 0;
  bit done_seen = 0;
  bit bad_addr = 0;
  bit rnd_gate = 0;
  bit gap_mode = 0;
  bit rclr = 0;
  int rptr = 0;
  string cur_tag = "R2";

  always @(posedge clk) if (wt_rd_en) wt_rd_data <= wmem[wt_rd_addr];

  assign rnd_valid = rnd_gate && (!gap_mode || (cyc % 3 == 0));
  assign rnd_data  = (rptr < NP) ? RW'(rlist[rptr]) : '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rclr) rptr <= 0;
    else if (rnd_valid && rnd_ready) rptr <= rptr + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wt_rd_en && int'(wt_rd_addr) >= cur_n) bad_addr = 1;
      if (out_valid) begin
        if (ocnt < cur_n) check(int'(out_index) == expv[ocnt], cur_tag, int'(out_index), expv[ocnt]);
        else check(0, "R4 extra index", ocnt + 1, cur_n);
        ocnt++;
      end
      if (done) begin
        check(ocnt == cur_n, "R4 count at done", ocnt, cur_n);
        check(!out_valid, "R4 done overlaps out_valid", int'(out_valid), 0);
        done_seen = 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // pat: 0 uniform, 1 ramp, 2 one heavy particle, 3 pseudo-random with zeros
  task automatic run_case(input int n, input int pat, input bit gap, input bit probe, input bit busy_start);
    int tot = 0;
    int lf = 8'h5a + n * 7 + pat;
    int reads = 0;
    int t = 0;
    for (int i = 0; i < NP; i++) begin
      int w;
      case (pat)
        0: w = 10;
        1: w = (i * 17 + 1) & 255;
        2: w = (i == n / 2) ? 200 : 0;
        default: begin
          lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 255;
          w = (lf % 4 == 0) ? 0 : lf;
        end
      endcase
      if (i >= n) w = 0;
      if (pat == 3 && i == 0 && n == 1) w = 9;
      wmem[i] = WW'(w);
      tot += w;
    end
    for (int k = 0; k < NP; k++) begin
      lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 255;
      if (lf == 0) lf = 1;
      rlist[k] = (k == 0) ? 0 : (k == 1) ? 255 : lf;
    end
    // Exact integer reference for R2.
    for (int k = 0; k < n; k++) begin
      longint cum = 0;
      expv[k] = n - 1;
      for (int i = 0; i < n; i++) begin
        cum += longint'(wmem[i]);
        if (cum * 256 > longint'(rlist[k]) * longint'(tot)) begin
          expv[k] = i;
          break;
        end
      end
    end
    cur_n = n;
    cur_tag = (pat == 2) ? "R7 zero weight emitted" : "R2 index mismatch";
    ocnt = 0;
    done_seen = 0;
    bad_addr = 0;
    gap_mode = gap;
    @(negedge clk);
    rclr = 1;
    rnd_gate = !probe;
    @(negedge clk);
    rclr = 0;
    num_particles = CW'(n);
    weight_total = TW'(tot);
    start = 1;
    @(negedge clk);
    start = 0;
    if (probe) begin
      for (int c = 0; c < 20; c++) begin
        if (wt_rd_en) reads++;
        @(negedge clk);
      end
      check(reads == ((n < PF) ? n : PF), "R10 prefetch reads", reads, (n < PF) ? n : PF);
      rnd_gate = 1;
    end
    if (busy_start) begin
      repeat (6) @(negedge clk);
      check(busy == 1'b1, "R1 busy during run", int'(busy), 1);
      num_particles = CW'((n == 1) ? 2 : 1);
      start = 1;
      @(negedge clk);
      start = 0;
      num_particles = CW'(n);
    end
    while (!done_seen && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done_seen, "R4 done seen", int'(done_seen), 1);
    check(rptr == n, "R3 random values taken", rptr, n);
    check(!bad_addr, "R6 read address range", int'(bad_addr), 0);
    @(negedge clk);
    check(!done && !busy, "R4 done single cycle and idle", int'(done) + int'(busy), 0);
    rnd_gate = 0;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      wmem[i] = '0;
      rlist[i] = 0;
      expv[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(!out_valid && !done && !busy && !rnd_ready && !wt_rd_en, "R9 reset state",
          int'(out_valid) + int'(done) + int'(busy) + int'(rnd_ready) + int'(wt_rd_en), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !rnd_ready, "R8 idle not ready", int'(rnd_ready), 0);
    run_case(1, 1, 0, 0, 0);
    run_case(2, 0, 0, 1, 0);
    run_case(3, 0, 1, 0, 0);
    run_case(5, 2, 0, 0, 0);
    run_case(7, 3, 0, 1, 0);
    run_case(8, 1, 1, 0, 0);
    run_case(13, 3, 1, 0, 1);
    run_case(16, 2, 0, 1, 0);
    run_case(16, 3, 0, 0, 1);
    run_case(11, 1, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule